// File: doc/BRIEF.md
# Logic Self-Test Supervisor

This block is the central sequencer for structural self-test across several hierarchical scan domains. Software programs a domain-enable mask and a configuration word over a simple register bus, then writes a start command. The supervisor first hands the configuration word to each selected domain controller, one at a time, and waits for each acknowledge. It then starts the selected domains strictly one after another with individual run requests and waits for each domain's done pulse. Once every selected domain has finished, it captures all domain signatures in a single cycle into readable registers.

After capture the supervisor raises a system reset request and holds it. It leaves that state only when software writes the reset bit, which returns the state machine to idle. A scan-mode output stays high for the whole sequence so that functional logic can be blocked. A sticky alarm output flags unwanted activity: a start command while a sequence is running, or a done pulse from a domain that was not asked to run. An error-injection bit can also force the alarm for testing. The domain controllers and the serial test-access network sit outside the block.

Top module: `stest_supervisor`

## Requirements
- R1: Register map, read combinationally from the current address: word 0 control (write bit 0 start, bit 1 reset, bit 2 error-inject; every write loads bit 2, reads return bit 2), word 1 configuration (bits [NUM_DOM-1:0] domain mask, bits [31:16] configuration word), word 2 status (bits [2:0] state with idle 0, configure 1, run 2, capture 3, hold 4; bit 4 busy; bit 5 alarm; bits [8+:NUM_DOM] done bitmap), word 4+d signature of domain d zero-extended, any other word reads 0.
- R2: A start write in idle moves to configure on that edge. One slot per clock edge at most, domains are visited in ascending order: a selected slot drives cfg_req_o with cfg_dom_o and cfg_word_o until cfg_ack_i is seen, an unselected slot costs one cycle, and one more cycle follows the last slot before the run phase.
- R3: In the run phase domains are visited in ascending order with the same slot timing; a selected domain gets its own run_req_o bit, alone, held until its dom_done_i pulse, after which the bit drops on that edge and the domain's done bitmap bit is set.
- R4: Unselected domains receive neither configuration nor run requests, their done bit stays 0 and their signature reads 0.
- R5: One cycle after the last slot of the run phase, a single capture cycle latches every selected domain's dom_sig_i; signatures and the done bitmap are cleared by an accepted start and kept through the reset bit.
- R6: After capture, sys_rst_req_o is raised and held, in the hold state, until the reset bit is written.
- R7: The reset bit returns the block to idle on that edge from any state, drops all requests and clears the sticky alarm; a write that sets both start and reset leaves the block idle.
- R8: scan_mode_o is high in every state other than idle.
- R9: A start write while not idle is ignored by the sequence and sets the sticky alarm.
- R10: A dom_done_i bit high while its run_req_o bit is low sets the sticky alarm.
- R11: alarm_o is high whenever the error-inject bit is set, with no effect on the sequence.
- R12: Configuration writes while not idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| cfg_req_o | output | 1 | Configuration request to the domain in cfg_dom_o |
| cfg_dom_o | output | IDX_W | Domain being configured |
| cfg_word_o | output | WORD_W | Configuration word handed to domains |
| cfg_ack_i | input | 1 | Configuration acknowledge |
| run_req_o | output | NUM_DOM | Per-domain run request |
| dom_done_i | input | NUM_DOM | Per-domain done pulse |
| dom_sig_i | input | NUM_DOM*SIG_W | Per-domain signature results |
| scan_mode_o | output | 1 | Device-wide scan mode |
| sys_rst_req_o | output | 1 | System reset request after the run |
| alarm_o | output | 1 | Unwanted activity alarm |

## Verification
The sequence is driven with a full mask, a sparse mask, an empty mask and a sparse mask after an aborted run, with domains that acknowledge and finish after different latencies; the full mask shows the ascending order and hand-offs, the sparse masks separate skipped slots from served ones and show zeroed signatures, and the empty mask shows the walk through all slots straight to capture. Disturbances are layered on top: a start and a configuration write during a run, a stray done pulse in idle, error injection in idle, a mid-run abort and a combined start-and-reset write, which tell apart the alarm causes and the ignore rules. A behavioural model in the bench tracks the expected outputs on every clock and register reads compare against values computed from the requirements.

// File: rtl/stest_pkg.sv
package stest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CFG  = 3'd1,
    ST_RUN  = 3'd2,
    ST_CAPT = 3'd3,
    ST_HOLD = 3'd4
  } st_e;

  localparam int REG_CTRL = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_SIG0 = 4;

  localparam int CTRL_START  = 0;
  localparam int CTRL_RESET  = 1;
  localparam int CTRL_ERRINJ = 2;

  localparam int STAT_BUSY    = 4;
  localparam int STAT_ALARM   = 5;
  localparam int STAT_DONE    = 8;
  localparam int CFG_WORD_LSB = 16;
endpackage

// File: rtl/stest_regif.sv
module stest_regif
  import stest_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int SIG_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_sel_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  input  logic                     busy_i,
  input  st_e                      state_i,
  input  logic                     alarm_i,
  input  logic [NUM_DOM-1:0]       done_map_i,
  input  logic [NUM_DOM*SIG_W-1:0] sig_i,
  output logic                     start_o,
  output logic                     swrst_o,
  output logic                     errinj_o,
  output logic [NUM_DOM-1:0]       mask_o,
  output logic [WORD_W-1:0]        word_o
);
  logic wr, ctrl_wr, cfg_wr;
  logic errinj_q;
  logic [NUM_DOM-1:0] mask_q;
  logic [WORD_W-1:0]  word_q;
  logic unused_wdata;

  assign wr      = bus_sel_i && bus_we_i;
  assign ctrl_wr = wr && (bus_addr_i == ADDR_W'(REG_CTRL));
  assign cfg_wr  = wr && (bus_addr_i == ADDR_W'(REG_CFG));
  assign start_o = ctrl_wr && bus_wdata_i[CTRL_START];
  assign swrst_o = ctrl_wr && bus_wdata_i[CTRL_RESET];
  assign unused_wdata = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      errinj_q <= 1'b0;
      mask_q   <= '0;
      word_q   <= '0;
    end else begin
      if (ctrl_wr) errinj_q <= bus_wdata_i[CTRL_ERRINJ];
      // configuration frozen while a sequence runs
      if (cfg_wr && !busy_i) begin
        mask_q <= bus_wdata_i[NUM_DOM-1:0];
        word_q <= bus_wdata_i[CFG_WORD_LSB +: WORD_W];
      end
    end
  end

  assign errinj_o = errinj_q;
  assign mask_o   = mask_q;
  assign word_o   = word_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(REG_CTRL)) begin
      bus_rdata_o[CTRL_ERRINJ] = errinj_q;
    end else if (bus_addr_i == ADDR_W'(REG_CFG)) begin
      bus_rdata_o[NUM_DOM-1:0]                = mask_q;
      bus_rdata_o[CFG_WORD_LSB +: WORD_W]     = word_q;
    end else if (bus_addr_i == ADDR_W'(REG_STAT)) begin
      bus_rdata_o[2:0]                   = state_i;
      bus_rdata_o[STAT_BUSY]             = busy_i;
      bus_rdata_o[STAT_ALARM]            = alarm_i;
      bus_rdata_o[STAT_DONE +: NUM_DOM]  = done_map_i;
    end
    for (int d = 0; d < NUM_DOM; d++) begin
      if (bus_addr_i == ADDR_W'(REG_SIG0 + d))
        bus_rdata_o[SIG_W-1:0] = sig_i[d*SIG_W +: SIG_W];
    end
  end
endmodule

// File: rtl/stest_seq.sv
module stest_seq
  import stest_pkg::*;
#(
  parameter int NUM_DOM = 4,
  localparam int CNT_W  = $clog2(NUM_DOM + 1),
  localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               swrst_i,
  input  logic [NUM_DOM-1:0] mask_i,
  input  logic               cfg_ack_i,
  input  logic [NUM_DOM-1:0] done_i,
  output st_e                state_o,
  output logic               busy_o,
  output logic               cfg_req_o,
  output logic [IDX_W-1:0]   cfg_dom_o,
  output logic [NUM_DOM-1:0] run_req_o,
  output logic [NUM_DOM-1:0] done_map_o,
  output logic               alarm_o,
  output logic               hold_o,
  output logic               clear_o,
  output logic               capture_o
);
  st_e                state_q;
  logic [CNT_W-1:0]   slot_q;
  logic [NUM_DOM-1:0] done_q;
  logic               alarm_q;
  logic               slot_end, slot_sel, slot_done, stray;

  assign slot_end = (slot_q == CNT_W'(NUM_DOM));

  always_comb begin
    slot_sel  = 1'b0;
    slot_done = 1'b0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (slot_q == CNT_W'(d)) begin
        slot_sel  = mask_i[d];
        slot_done = done_i[d];
      end
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_run
    assign run_req_o[d] = (state_q == ST_RUN) && (slot_q == CNT_W'(d)) && mask_i[d];
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign cfg_req_o = (state_q == ST_CFG) && slot_sel;
  assign cfg_dom_o = IDX_W'(slot_q);
  assign stray     = |(done_i & ~run_req_o);
  assign clear_o   = (state_q == ST_IDLE) && start_i && !swrst_i;
  assign capture_o = (state_q == ST_CAPT) && !swrst_i;
  assign hold_o    = (state_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      done_q  <= '0;
      alarm_q <= 1'b0;
    end else if (swrst_i) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (stray || (start_i && busy_o)) alarm_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CFG;
          slot_q  <= '0;
          done_q  <= '0;
        end
        ST_CFG: begin
          if (slot_end) begin
            state_q <= ST_RUN;
            slot_q  <= '0;
          end else if (!slot_sel || cfg_ack_i) begin
            slot_q <= slot_q + CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (slot_end) begin
            state_q <= ST_CAPT;
          end else if (!slot_sel) begin
            slot_q <= slot_q + CNT_W'(1);
          end else if (slot_done) begin
            done_q <= done_q | run_req_o;
            slot_q <= slot_q + CNT_W'(1);
          end
        end
        ST_CAPT: state_q <= ST_HOLD;
        ST_HOLD: state_q <= ST_HOLD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign done_map_o = done_q;
  assign alarm_o    = alarm_q;
endmodule

// File: rtl/stest_sig_bank.sv
module stest_sig_bank #(
  parameter int NUM_DOM = 4,
  parameter int SIG_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     capture_i,
  input  logic [NUM_DOM-1:0]       mask_i,
  input  logic [NUM_DOM*SIG_W-1:0] sig_i,
  output logic [NUM_DOM*SIG_W-1:0] sig_o
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_sig
    logic [SIG_W-1:0] sig_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   sig_q <= '0;
      else if (clear_i)              sig_q <= '0;
      else if (capture_i)            sig_q <= mask_i[d] ? sig_i[d*SIG_W +: SIG_W] : '0;
    end
    assign sig_o[d*SIG_W +: SIG_W] = sig_q;
  end
endmodule

// File: rtl/stest_supervisor.sv
module stest_supervisor
  import stest_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int SIG_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_sel_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  output logic                     cfg_req_o,
  output logic [IDX_W-1:0]         cfg_dom_o,
  output logic [WORD_W-1:0]        cfg_word_o,
  input  logic                     cfg_ack_i,
  output logic [NUM_DOM-1:0]       run_req_o,
  input  logic [NUM_DOM-1:0]       dom_done_i,
  input  logic [NUM_DOM*SIG_W-1:0] dom_sig_i,
  output logic                     scan_mode_o,
  output logic                     sys_rst_req_o,
  output logic                     alarm_o
);
  st_e                      state;
  logic                     busy, start, swrst, errinj, alarm_sticky;
  logic                     clear, capture, hold;
  logic [NUM_DOM-1:0]       mask, done_map;
  logic [NUM_DOM*SIG_W-1:0] sig_q;

  stest_regif #(
    .NUM_DOM(NUM_DOM), .SIG_W(SIG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)
  ) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy),
    .state_i     (state),
    .alarm_i     (alarm_o),
    .done_map_i  (done_map),
    .sig_i       (sig_q),
    .start_o     (start),
    .swrst_o     (swrst),
    .errinj_o    (errinj),
    .mask_o      (mask),
    .word_o      (cfg_word_o)
  );

  stest_seq #(.NUM_DOM(NUM_DOM)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .swrst_i    (swrst),
    .mask_i     (mask),
    .cfg_ack_i  (cfg_ack_i),
    .done_i     (dom_done_i),
    .state_o    (state),
    .busy_o     (busy),
    .cfg_req_o  (cfg_req_o),
    .cfg_dom_o  (cfg_dom_o),
    .run_req_o  (run_req_o),
    .done_map_o (done_map),
    .alarm_o    (alarm_sticky),
    .hold_o     (hold),
    .clear_o    (clear),
    .capture_o  (capture)
  );

  stest_sig_bank #(.NUM_DOM(NUM_DOM), .SIG_W(SIG_W)) u_sig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .capture_i (capture),
    .mask_i    (mask),
    .sig_i     (dom_sig_i),
    .sig_o     (sig_q)
  );

  assign scan_mode_o   = busy;
  assign sys_rst_req_o = hold;
  assign alarm_o       = alarm_sticky | errinj;
endmodule

// File: rtl/stest_supervisor_chk.sv
module stest_supervisor_chk #(
  parameter int NUM_DOM = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_sel_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic               cfg_req_o,
  input logic [NUM_DOM-1:0] run_req_o,
  input logic [NUM_DOM-1:0] dom_done_i,
  input logic               scan_mode_o,
  input logic               sys_rst_req_o,
  input logic               alarm_o
);
  logic ctrl_wr, sw_rst, unused_wdata;
  assign ctrl_wr = bus_sel_i && bus_we_i && (bus_addr_i == '0);
  assign sw_rst  = ctrl_wr && bus_wdata_i[1];
  assign unused_wdata = ^bus_wdata_i;

  assert_run_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(run_req_o));

  assert_no_cfg_during_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_req_o && (|run_req_o)));

  assert_run_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|run_req_o) && !(|(run_req_o & dom_done_i)) && !sw_rst) |=> (run_req_o == $past(run_req_o)));

  assert_run_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(run_req_o & dom_done_i)) |=> !(|(run_req_o & $past(run_req_o))));

  assert_scan_covers_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o || (|run_req_o) || sys_rst_req_o) |-> scan_mode_o);

  assert_hold_until_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o && !sw_rst) |=> sys_rst_req_o);

  assert_no_req_in_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> (run_req_o == '0 && !cfg_req_o));

  assert_reset_to_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst |=> (!scan_mode_o && !sys_rst_req_o && run_req_o == '0 && !cfg_req_o));

  assert_busy_start_alarm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && bus_wdata_i[0] && !bus_wdata_i[1] && scan_mode_o) |=> alarm_o);

  assert_stray_done_alarm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(dom_done_i & ~run_req_o)) && !sw_rst) |=> alarm_o);

  assert_errinj_alarm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && bus_wdata_i[2]) |=> alarm_o);
endmodule

bind stest_supervisor stest_supervisor_chk #(
  .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_sel_i     (bus_sel_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .cfg_req_o     (cfg_req_o),
  .run_req_o     (run_req_o),
  .dom_done_i    (dom_done_i),
  .scan_mode_o   (scan_mode_o),
  .sys_rst_req_o (sys_rst_req_o),
  .alarm_o       (alarm_o)
);

// File: tb/stest_supervisor_bench.sv
module stest_supervisor_bench;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int WW = 16;

  logic clk, rst_n;
  logic bus_sel_i, bus_we_i;
  logic [AW-1:0] bus_addr_i;
  logic [DW-1:0] bus_wdata_i, bus_rdata_o;
  logic cfg_req_o, cfg_ack_i;
  logic [1:0] cfg_dom_o;
  logic [WW-1:0] cfg_word_o;
  logic [N-1:0] run_req_o, dom_done_i;
  logic [N*SW-1:0] dom_sig_i;
  logic scan_mode_o, sys_rst_req_o, alarm_o;

  int checks = 0, errors = 0, cyc = 0, run_no = 0;

  stest_supervisor u_stest_supervisor (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .cfg_req_o(cfg_req_o), .cfg_dom_o(cfg_dom_o), .cfg_word_o(cfg_word_o),
    .cfg_ack_i(cfg_ack_i), .run_req_o(run_req_o), .dom_done_i(dom_done_i),
    .dom_sig_i(dom_sig_i), .scan_mode_o(scan_mode_o),
    .sys_rst_req_o(sys_rst_req_o), .alarm_o(alarm_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] sig_val(int d, int r);
    return 16'((49152 ^ (d * 273) ^ (r * 19)) + 1);
  endfunction

  always_comb begin
    for (int d = 0; d < N; d++) dom_sig_i[d*SW +: SW] = sig_val(d, run_no);
  end

  // behavioural reference: state 0 idle,1 cfg,2 run,3 capture,4 hold
  int m_st, m_slot;
  logic [N-1:0] m_mask, m_done;
  logic [15:0] m_word;
  logic m_err, m_alarm;
  logic [15:0] m_sig [N];

  function automatic logic [N-1:0] exp_run();
    logic [N-1:0] v = '0;
    if (m_st == 2 && m_slot < N && m_mask[m_slot]) v[m_slot] = 1'b1;
    return v;
  endfunction

  function automatic logic exp_cfg();
    return (m_st == 1 && m_slot < N && m_mask[m_slot]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_mask = '0; m_done = '0; m_word = '0;
      m_err = 0; m_alarm = 0;
      for (int d = 0; d < N; d++) m_sig[d] = '0;
    end else begin
      logic cw, fw, stray;
      cw = bus_sel_i && bus_we_i && bus_addr_i == 0;
      fw = bus_sel_i && bus_we_i && bus_addr_i == 1;
      stray = |(dom_done_i & ~exp_run());
      if (cw) m_err = bus_wdata_i[2];
      if (cw && bus_wdata_i[1]) begin
        m_st = 0; m_slot = 0; m_alarm = 0;
      end else begin
        if (stray || (cw && bus_wdata_i[0] && m_st != 0)) m_alarm = 1;
        if (fw && m_st == 0) begin
          m_mask = bus_wdata_i[N-1:0];
          m_word = bus_wdata_i[31:16];
        end
        case (m_st)
          0: if (cw && bus_wdata_i[0]) begin
               m_st = 1; m_slot = 0; m_done = '0;
               for (int d = 0; d < N; d++) m_sig[d] = '0;
             end
          1: if (m_slot == N) begin m_st = 2; m_slot = 0; end
             else if (!m_mask[m_slot] || cfg_ack_i) m_slot++;
          2: if (m_slot == N) m_st = 3;
             else if (!m_mask[m_slot]) m_slot++;
             else if (dom_done_i[m_slot]) begin m_done[m_slot] = 1; m_slot++; end
          3: begin
               for (int d = 0; d < N; d++)
                 m_sig[d] = m_mask[d] ? dom_sig_i[d*SW +: SW] : '0;
               m_st = 4;
             end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // domain responders, per-cycle comparison, watchdog
  int cfg_cnt = 0;
  int run_cnt [N];
  logic [N-1:0] stray_req = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] dn;
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL R6 watchdog act=hung exp=finished");
        finish_run();
      end
      chk("R8 scan_mode", 32'(scan_mode_o), 32'(m_st != 0));
      chk("R6 sys_rst_req", 32'(sys_rst_req_o), 32'(m_st == 4));
      chk("R9/R10/R11 alarm", 32'(alarm_o), 32'(m_alarm | m_err));
      chk("R3 run_req", 32'(run_req_o), 32'(exp_run()));
      chk("R2 cfg_req", 32'(cfg_req_o), 32'(exp_cfg()));
      if (cfg_req_o) begin
        chk("R2 cfg_dom", 32'(cfg_dom_o), 32'(m_slot));
        chk("R2 cfg_word", 32'(cfg_word_o), 32'(m_word));
      end
      if (cfg_ack_i) begin
        cfg_ack_i = 1'b0; cfg_cnt = 0;
      end else if (cfg_req_o) begin
        cfg_cnt++;
        if (cfg_cnt >= 2 + int'(cfg_dom_o)) cfg_ack_i = 1'b1;
      end else cfg_cnt = 0;
      dn = '0;
      for (int d = 0; d < N; d++) begin
        if (dom_done_i[d]) run_cnt[d] = 0;
        else if (run_req_o[d]) begin
          run_cnt[d]++;
          if (run_cnt[d] >= 3 + 2 * d) dn[d] = 1'b1;
        end else run_cnt[d] = 0;
      end
      dom_done_i = dn | stray_req;
      stray_req = '0;
    end
  end

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = AW'(a); bus_wdata_i = v;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr_i = AW'(a);
    #1 v = bus_rdata_o;
  endtask

  task automatic wait_hold();
    int n = 0;
    while (!sys_rst_req_o && n < 2000) begin @(negedge clk); n++; end
    #1;
  endtask

  task automatic wait_run(input int d);
    int n = 0;
    while (!run_req_o[d] && n < 2000) begin @(negedge clk); n++; end
    #1;
  endtask

  function automatic logic [31:0] stat(int st, logic busy, logic al, logic [N-1:0] dm);
    return 32'(st) | (32'(busy) << 4) | (32'(al) << 5) | (32'(dm) << 8);
  endfunction

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_sel_i = 0; bus_we_i = 0; bus_addr_i = '0; bus_wdata_i = '0;
    cfg_ack_i = 0; dom_done_i = '0;
    for (int d = 0; d < N; d++) run_cnt[d] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(2, v); chk("R1 status after reset", v, 32'h0);
    chk("R8 scan low after reset", 32'(scan_mode_o), 0);

    // full mask run
    wr(1, 32'h1234_000F);
    rd(1, v); chk("R1 cfg readback", v, 32'h1234_000F);
    run_no = 1;
    wr(0, 32'h1);
    wait_hold();
    rd(2, v); chk("R6 hold status", v, stat(4, 1, 0, 4'hF));
    for (int d = 0; d < N; d++) begin
      rd(4 + d, v); chk("R5 signature full", v, 32'(sig_val(d, 1)));
    end
    repeat (5) @(negedge clk);
    chk("R6 request held", 32'(sys_rst_req_o), 1);
    wr(0, 32'h2);
    rd(2, v); chk("R7 idle after reset bit", v, stat(0, 0, 0, 4'hF));
    rd(4, v); chk("R5 signature kept through reset", v, 32'(sig_val(0, 1)));
    rd(9, v); chk("R1 unmapped reads zero", v, 0);

    // sparse mask with busy start and busy cfg write
    wr(1, 32'hBEEF_0005);
    run_no = 2;
    wr(0, 32'h1);
    wait_run(0);
    wr(0, 32'h1);
    rd(2, v); chk("R9 busy start alarm", v[5], 1);
    wr(1, 32'h5555_000F);
    rd(1, v); chk("R12 cfg write ignored while busy", v, 32'hBEEF_0005);
    wait_hold();
    rd(2, v); chk("R4 sparse done map", v, stat(4, 1, 1, 4'h5));
    for (int d = 0; d < N; d++) begin
      rd(4 + d, v);
      chk("R4 sparse signature", v, (d % 2 == 0) ? 32'(sig_val(d, 2)) : 32'h0);
    end
    wr(0, 32'h2);
    rd(2, v); chk("R7 alarm cleared by reset", v[5], 0);

    // empty mask
    wr(1, 32'h0000_0000);
    run_no = 3;
    wr(0, 32'h1);
    wait_hold();
    rd(2, v); chk("R4 empty mask hold", v, stat(4, 1, 0, 4'h0));
    rd(5, v); chk("R5 signature cleared at start", v, 0);
    wr(0, 32'h2);

    // error injection
    wr(0, 32'h4);
    rd(2, v); chk("R11 injected alarm, idle", v, stat(0, 0, 1, 4'h0));
    rd(0, v); chk("R1 errinj readback", v, 32'h4);
    wr(0, 32'h0);
    chk("R11 alarm off after clear", 32'(alarm_o), 0);

    // stray done pulse in idle
    @(posedge clk); #1 stray_req = 4'b0010;
    repeat (3) @(negedge clk);
    rd(2, v); chk("R10 stray done alarm", v, stat(0, 0, 1, 4'h0));
    wr(0, 32'h2);
    chk("R7 stray alarm cleared", 32'(alarm_o), 0);

    // abort mid-run, then start+reset together
    wr(1, 32'h00AA_000F);
    run_no = 4;
    wr(0, 32'h1);
    wait_run(1);
    wr(0, 32'h2);
    rd(2, v); chk("R7 abort to idle", v[4:0], 0);
    chk("R7 run dropped", 32'(run_req_o), 0);
    wr(0, 32'h3);
    rd(2, v); chk("R7 start with reset stays idle", v[4:0], 0);

    // clean restart with sparse mask
    wr(1, 32'h00AA_000A);
    run_no = 5;
    wr(0, 32'h1);
    wait_hold();
    rd(2, v); chk("R3 restart done map", v, stat(4, 1, 0, 4'hA));
    for (int d = 0; d < N; d++) begin
      rd(4 + d, v);
      chk("R4 restart signature", v, (d % 2 == 1) ? 32'(sig_val(d, 5)) : 32'h0);
    end
    wr(0, 32'h2);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule